// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial protocol engine of a small byte-wide non-volatile memory and its storage array. The engine hands it a word address once per write command and then one strobe per received data byte. The buffer keeps those bytes in an on-chip page latch. It moves them to the array only when the engine reports a stop condition.

The latch covers one physical page of `PAGE_BYTES` bytes. The upper address bits are frozen at the page chosen by the word address. Only the low slot bits advance after each byte, so a long burst wraps to the start of the same page. A late byte replaces an earlier one in the same slot; it never spills into the next page. Each slot carries a valid bit, so bytes that never arrived leave the array untouched.

On a stop with at least one byte held, the block raises `busy` for exactly `WRITE_CYCLES` clock cycles. This models the self-timed programming cycle. The first `PAGE_BYTES` cycles of that window walk the slots in ascending order and issue one array write per valid slot. At the end of the window the valid mask clears. While `busy` is high, the engine withholds acknowledges, and the block ignores every strobe it receives. A repeated start during the data phase drops the held bytes. A stop with nothing held, such as after the address phase of a random read, starts no cycle.

Top module: `pwb_top`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, `busy` and `mem_we` are 0.
- R2: A byte received with word address A is committed to array address {A[ADDR_W-1:SLOT_W], slot}, where slot starts at A[SLOT_W-1:0] (SLOT_W = 3 for 8-byte pages).
- R3: After each accepted byte only the low SLOT_W address bits increment, modulo PAGE_BYTES. A burst that starts mid-page wraps to offset 0 of the same page and never writes the next page.
- R4: When more than PAGE_BYTES bytes arrive before stop, the last byte received for each slot is the one committed, and each slot is written at most once.
- R5: A stop accepted while at least one byte is held raises `busy` on the next clock edge. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R6: During a commit, `mem_we` pulses once per valid slot and for no other slot. Pulses fall only inside the busy window, in ascending slot order, and all share one page address.
- R7: A stop accepted with no byte held leaves `busy` low and issues no array write.
- R8: A repeated-start strobe while idle clears all held bytes. A following stop then writes nothing and does not raise `busy`.
- R9: While `busy` is high, address loads, data strobes, stop strobes and repeated-start strobes have no effect.
- R10: The valid mask is empty when `busy` falls. A second stop with no new bytes produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_load | input | 1 | One-cycle strobe: load word address |
| addr_value | input | ADDR_W | Word address for `addr_load` |
| data_valid | input | 1 | One-cycle strobe: a data byte was received |
| data_value | input | DATA_W | Data byte for `data_valid` |
| stop_seen | input | 1 | One-cycle strobe: stop condition detected |
| restart_seen | input | 1 | One-cycle strobe: repeated start during the data phase |
| mem_we | output | 1 | Array write enable, one cycle per byte |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench aims at the page-edge cases:
- A burst starting at offset 5 of a page. A design that carried into the upper bits would write into the next page, and that page's first byte would be non-zero.
- An 11-byte burst. A design that counted bytes instead of tracking slots would issue eleven writes instead of eight, or would keep the first byte of an overwritten slot.
- A stop after an address-only command, a repeated start followed by a stop, and a second stop straight after a commit. Each shows whether a design raises `busy` or writes stale data without cause.
- A volley of strobes inside the busy window. A design that did not freeze during the commit would corrupt the page being written or would start a second cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Phases of the commit sequencer
  typedef enum logic [1:0] {
    PH_FILL   = 2'd0,  // collecting bytes, not busy
    PH_WALK   = 2'd1,  // stepping through slots, writing valid ones
    PH_SETTLE = 2'd2   // remaining self-timed cycles
  } pwb_phase_e;
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 3,
  localparam int PAGE_W = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [PAGE_W-1:0] page_q,
  output logic [SLOT_W-1:0] slot_q
);
  logic [PAGE_W-1:0] page_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    page_d = page_q;
    slot_d = slot_q;
    if (load) begin
      page_d = load_addr[ADDR_W-1:SLOT_W];
      slot_d = load_addr[SLOT_W-1:0];
    end else if (step) begin
      slot_d = slot_q + SLOT_W'(1);  // wraps inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      slot_q <= '0;
    end else if (load || step) begin
      page_q <= page_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int PAGE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clr,
  input  logic [SLOT_W-1:0]     rd_slot,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [PAGE_BYTES-1:0] mask
);
  logic [PAGE_BYTES*DATA_W-1:0] data_flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
    logic              hit;
    logic              vld_q;
    logic              vld_d;
    logic [DATA_W-1:0] cell_q;

    assign hit = wr_en && (wr_slot == SLOT_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vld_q <= 1'b0;
      else if (clr || hit) vld_q <= vld_d;
    end

    // datapath cell: no reset needed, guarded by the valid bit
    always_ff @(posedge clk) begin
      if (hit) cell_q <= wr_data;
    end

    assign data_flat[g*DATA_W +: DATA_W] = cell_q;
    assign mask[g] = vld_q;
  end

  assign rd_data  = data_flat[rd_slot*DATA_W +: DATA_W];
  assign rd_valid = mask[rd_slot];
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 40,
  localparam int SLOT_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W       = $clog2(WRITE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              walk_en,
  output logic [SLOT_W-1:0] walk_slot,
  output logic              done
);
  localparam logic [CNT_W-1:0] WALK_LAST = CNT_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] CYC_LAST  = CNT_W'(WRITE_CYCLES - 1);

  pwb_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    cnt_en  = 1'b1;
    done    = 1'b0;
    unique case (phase_q)
      PH_FILL: begin
        cnt_d  = '0;
        cnt_en = start;
        if (start) phase_d = PH_WALK;
      end
      PH_WALK: begin
        if (cnt_q == WALK_LAST) phase_d = PH_SETTLE;
      end
      PH_SETTLE: begin
        if (cnt_q == CYC_LAST) begin
          phase_d = PH_FILL;
          done    = 1'b1;
        end
      end
      default: phase_d = PH_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy      = (phase_q != PH_FILL);
  assign walk_en   = (phase_q == PH_WALK);
  assign walk_slot = cnt_q[SLOT_W-1:0];
endmodule

// File: rtl/pwb_top.sv
module pwb_top #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 40,   // must exceed PAGE_BYTES
  localparam int SLOT_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_value,
  input  logic              stop_seen,
  input  logic              restart_seen,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  logic                  rst_n_i;
  logic                  idle;
  logic                  take_addr, take_byte, take_stop, take_drop;
  logic [PAGE_W-1:0]     page_q;
  logic [SLOT_W-1:0]     slot_q;
  logic [SLOT_W-1:0]     walk_slot;
  logic                  walk_en, seq_done;
  logic                  rd_valid;
  logic [PAGE_BYTES-1:0] fill_mask;

  pwb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // Strobes take effect only outside the self-timed window
  assign idle      = ~busy;
  assign take_drop = idle & restart_seen;
  assign take_addr = idle & addr_load & ~restart_seen;
  assign take_byte = idle & data_valid & ~restart_seen;
  assign take_stop = idle & stop_seen & ~restart_seen & (|fill_mask);

  pwb_ptr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (take_addr),
    .load_addr (addr_value),
    .step      (take_byte),
    .page_q    (page_q),
    .slot_q    (slot_q)
  );

  pwb_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (take_byte),
    .wr_slot  (slot_q),
    .wr_data  (data_value),
    .clr      (take_drop | seq_done),
    .rd_slot  (walk_slot),
    .rd_data  (mem_wdata),
    .rd_valid (rd_valid),
    .mask     (fill_mask)
  );

  pwb_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (take_stop),
    .busy      (busy),
    .walk_en   (walk_en),
    .walk_slot (walk_slot),
    .done      (seq_done)
  );

  assign mem_we   = walk_en & rd_valid;
  assign mem_addr = {page_q, walk_slot};
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 40,
  localparam int SLOT_W      = $clog2(PAGE_BYTES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic                  stop_seen,
  input logic                  restart_seen,
  input logic [PAGE_BYTES-1:0] fill_mask
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R1 / R6: writes only inside the busy window
  a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5: busy window length
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == WRITE_CYCLES);

  // R3 / R6: one page per commit, ascending slots
  a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      mem_addr[ADDR_W-1:SLOT_W] == $past(mem_addr[ADDR_W-1:SLOT_W]));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      mem_addr[SLOT_W-1:0] > $past(mem_addr[SLOT_W-1:0]));

  // R7: empty stop starts nothing
  a_r7_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !busy && fill_mask == '0) |=> !busy);

  // R8: repeated start drops the page
  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_seen && !busy) |=> fill_mask == '0);

  // R9: latch frozen during the window
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fill_mask));

  // R10: mask empty once the window ends
  a_r10_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fill_mask == '0);
endmodule

bind pwb_top pwb_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .stop_seen    (stop_seen),
  .restart_seen (restart_seen),
  .fill_mask    (fill_mask)
);

// File: tb/sim_pwb_top.sv
module sim_pwb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WC         = 40;

  logic       clk, rst_n;
  logic       addr_load, data_valid, stop_seen, restart_seen;
  logic [7:0] addr_value, data_value;
  logic       mem_we, busy;
  logic [7:0] mem_addr, mem_wdata;

  pwb_top #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_value(addr_value),
    .data_valid(data_valid), .data_value(data_value), .stop_seen(stop_seen),
    .restart_seen(restart_seen), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] obs_mem [256];
  logic [7:0] ref_mem [256];
  int wr_cnt = 0, busy_cnt = 0, order_err = 0, last_slot = -1;
  logic prev_busy = 1'b0;

  // reference page model
  logic [7:0] m_buf [8];
  bit   [7:0] m_vld;
  logic [4:0] m_page;
  logic [2:0] m_slot;

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (busy && !prev_busy) last_slot = -1;
    if (mem_we) begin
      obs_mem[mem_addr] = mem_wdata;
      wr_cnt++;
      if (int'(mem_addr[2:0]) <= last_slot) order_err++;
      last_slot = int'(mem_addr[2:0]);
    end
    if (busy) busy_cnt++;
    prev_busy = busy;
  end

  task automatic chk(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic clear_in();
    addr_load = 0; data_valid = 0; stop_seen = 0; restart_seen = 0;
  endtask

  task automatic do_addr(input logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_value = a;
    @(negedge clk); clear_in();
    if (!busy) begin m_page = a[7:3]; m_slot = a[2:0]; end
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(negedge clk); data_valid = 1; data_value = d;
    @(negedge clk); clear_in();
  endtask

  task automatic model_byte(input logic [7:0] d);
    m_buf[m_slot] = d; m_vld[m_slot] = 1'b1; m_slot = m_slot + 3'd1;
  endtask

  task automatic do_restart();
    @(negedge clk); restart_seen = 1;
    @(negedge clk); clear_in();
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 256; i++) if (obs_mem[i] !== ref_mem[i]) d++;
    return d;
  endfunction

  // stop, then check busy, busy length, write count and array image
  task automatic do_stop_check(input string req);
    int exp_wr, wr0, b0, guard;
    bit exp_busy;
    exp_wr = $countones(m_vld);
    exp_busy = (exp_wr != 0);
    for (int s = 0; s < 8; s++)
      if (m_vld[s]) ref_mem[{m_page, 3'(s)}] = m_buf[s];
    m_vld = '0;
    wr0 = wr_cnt; b0 = busy_cnt;
    @(negedge clk); stop_seen = 1;
    @(negedge clk); clear_in();
    chk({req, " R5/R7 busy after stop"}, int'(busy), int'(exp_busy));
    guard = 0;
    while (busy && guard < 4*WC) begin @(negedge clk); guard++; end
    chk({req, " R5 busy length"}, busy_cnt - b0, exp_busy ? WC : 0);
    chk({req, " R6 write count"}, wr_cnt - wr0, exp_wr);
    chk({req, " R2/R4 array image mismatches"}, mem_diff(), 0);
  endtask

  initial begin
    logic [7:0] b [12];
    clear_in(); addr_value = 0; data_value = 0;
    for (int i = 0; i < 256; i++) begin obs_mem[i] = 0; ref_mem[i] = 0; end
    m_vld = '0; m_page = 0; m_slot = 0;
    void'($urandom(32'd20240611));
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 we in reset", int'(mem_we), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 no writes after reset", wr_cnt, 0);

    // R7: address-only command then stop
    do_addr(8'h20);
    do_stop_check("R7 empty");

    // R2: single byte
    do_addr(8'h53); do_byte(8'hA5); model_byte(8'hA5);
    do_stop_check("R2 single");
    chk("R2 byte at 0x53", int'(obs_mem[8'h53]), 8'hA5);

    // R3: wrap inside page from offset 5
    do_addr(8'h3D);
    for (int i = 0; i < 5; i++) begin
      do_byte(8'(8'h11 * (i + 1))); model_byte(8'(8'h11 * (i + 1)));
    end
    do_stop_check("R3 wrap");
    chk("R3 wrapped byte at page start", int'(obs_mem[8'h38]), 8'h44);
    chk("R3 next page untouched", int'(obs_mem[8'h40]), 0);

    // R4: eleven bytes into one page
    do_addr(8'h10);
    for (int i = 0; i < 11; i++) begin
      do_byte(8'(8'hC0 + i)); model_byte(8'(8'hC0 + i));
    end
    do_stop_check("R4 overwrite");
    chk("R4 last value wins slot0", int'(obs_mem[8'h10]), 8'hC8);

    // R8: restart drops bytes
    do_addr(8'h70); do_byte(8'h99); do_byte(8'h98);
    do_restart();
    m_vld = '0;
    do_stop_check("R8 drop");
    chk("R8 nothing at 0x70", int'(obs_mem[8'h70]), 0);

    // R9 / R10: strobes during busy ignored, mask cleared
    do_addr(8'hA0); do_byte(8'h5A); model_byte(8'h5A);
    for (int s = 0; s < 8; s++)
      if (m_vld[s]) ref_mem[{m_page, 3'(s)}] = m_buf[s];
    m_vld = '0;
    begin
      int wr0;
      wr0 = wr_cnt;
      @(negedge clk); stop_seen = 1;
      @(negedge clk); clear_in();
      chk("R5 busy raised", int'(busy), 1);
      do_addr(8'hE0); do_byte(8'h77); do_byte(8'h66);
      do_restart();
      @(negedge clk); stop_seen = 1;
      @(negedge clk); clear_in();
      while (busy) @(negedge clk);
      chk("R9 writes during window", wr_cnt - wr0, 1);
      chk("R9 address load ignored 0xE0", int'(obs_mem[8'hE0]), 0);
      chk("R9 page intact 0xA0", int'(obs_mem[8'hA0]), 8'h5A);
      repeat (3) @(negedge clk);
      chk("R9 no second cycle", int'(busy), 0);
    end
    do_stop_check("R10 repeat stop");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int n, k;
      logic [7:0] a;
      a = 8'($urandom);
      n = $urandom_range(0, 12);
      do_addr(a);
      for (int i = 0; i < n; i++) begin
        b[i] = 8'($urandom_range(1, 255));
        do_byte(b[i]); model_byte(b[i]);
      end
      if ($urandom_range(0, 4) == 0) begin
        do_restart(); m_vld = '0;
        k = $urandom_range(0, 3);
        if (k != 0) begin
          do_addr(8'($urandom));
          for (int i = 0; i < k; i++) begin
            b[i] = 8'($urandom_range(1, 255));
            do_byte(b[i]); model_byte(b[i]);
          end
        end
      end
      do_stop_check("R2/R3/R4/R6 random");
    end
    chk("R6 ascending slot order errors", order_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule